// File: doc/BRIEF.md
# Three-Wire Serial Register Readout

This block is the slave side of a three-wire serial link: an active-low select, a serial clock driven by the master, and one data line that carries command bits towards the block and returns data from it. While selected, the block collects an 8-bit command made of two 4-bit fields. If the command asks for the data holding register, the block turns the shared line around and returns the 16-bit parallel word presented on `hold_word`. The word goes out most significant bit first. The pad itself sits outside the block: `sdio_in`, `sdio_out` and `sdio_oe` drive a bidirectional buffer.

All pins are sampled into the system clock domain through a synchronizer. The serial clock edges are detected from the synchronized samples. A controller with four states runs each frame. `ST_IDLE` waits for select (transition *select*). `ST_CMD` shifts in the command bits. When the last command bit arrives, *cmd_hit* enters `ST_READ` and *cmd_miss* enters `ST_HOLD`. `ST_READ` drives the 16 bits and leaves on *word_done* to `ST_HOLD`. `ST_HOLD` keeps the line released for the rest of the frame. Releasing select takes every state back to `ST_IDLE` (transition *release*).

Top module: `tws_readout`

## Requirements
- R1: After reset, `sdio_oe` and `sdio_out` are 0.
- R2: Command bits are taken on rising serial clock edges. The first 4 bits form the address field and the next 4 bits form the data field, each field least significant bit first. The wire sequence 1,0,0,1,1,0,0,0 is address 9 with data 1, and this command starts a readout.
- R3: After a readout command, `hold_word` is returned one bit per falling serial clock edge, starting with bit 15 and ending with bit 0. The master takes each bit on the following rising edge.
- R4: The word is captured when the last command bit is taken. Changes on `hold_word` after that point do not alter the bits returned in this frame.
- R5: `sdio_oe` rises on the first falling edge after the command and falls on the falling edge that follows the sixteenth data bit.
- R6: Any other command leaves `sdio_oe` low for the rest of the frame.
- R7: Raising `cs_n` aborts the frame at any point, whether during the command or during the readout. `sdio_oe` is low within four system clocks, and the next frame starts again at command bit 0.
- R8: `sdio_oe` is never high while the synchronized select is inactive.
- R9: Serial clocks beyond the sixteenth data bit in the same frame do not drive the line again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the master |
| sclk | input | 1 | Serial clock from the master, idle low |
| sdio_in | input | 1 | Data line as received at the pad |
| sdio_out | output | 1 | Data bit driven towards the pad |
| sdio_oe | output | 1 | Pad output enable for the data line |
| hold_word | input | 16 | Parallel data holding register value |

## Verification
The hardest case to reach is an abort that lands inside the readout window. Here the frame ends with part of the captured word still unsent. The next frame must then start cleanly from command bit 0, with no leftover count and no leftover enable. The driver gets there by ending a frame after 13 serial clocks, then at once sending a full read whose word differs in every bit position that was left unsent. A second situation is the capture instant. The driver changes `hold_word` on the falling edge right after the last command bit, so a late capture shows up as corrupted bits.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_READ = 2'd2,
        ST_HOLD = 2'd3
    } tws_state_e;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= {stage_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/tws_shift.sv
module tws_shift #(
    parameter int WORD_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 shift_en,
    input  logic [WORD_BITS-1:0] par_in,
    output logic                 sdo
);

    logic [WORD_BITS-1:0] data_q;
    logic                 sdo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            sdo_q  <= 1'b0;
        end else if (load) begin
            data_q <= par_in;
        end else if (shift_en) begin
            sdo_q  <= data_q[WORD_BITS-1];
            data_q <= {data_q[WORD_BITS-2:0], 1'b0};
        end
    end

    assign sdo = sdo_q;

    // R4: the captured word only moves on a capture or a shift
    a_r4_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift_en) |=> $stable(data_q));

    // R3: the output bit changes only on a shift
    a_r3_sdo_moves_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sdo_q));

endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
    import tws_pkg::*;
#(
    parameter int FIELD_BITS = 4,
    parameter int WORD_BITS  = 16,
    parameter int READ_ADDR  = 9,
    parameter int READ_DATA  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_act,
    input  logic sclk_rise,
    input  logic sclk_fall,
    input  logic din,
    output logic load,
    output logic shift_en,
    output logic oe
);

    localparam int CMD_BITS = 2 * FIELD_BITS;
    localparam int CNT_W    = $clog2(WORD_BITS + 1);
    localparam int IDX_W    = $clog2(CMD_BITS);
    localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS);

    tws_state_e state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [CMD_BITS-1:0] cmd_q, cmd_next;
    logic                oe_q;
    logic                cmd_last, cmd_hit;

    always_comb begin
        cmd_next = cmd_q;
        cmd_next[cnt_q[IDX_W-1:0]] = din;
    end

    assign cmd_last = (state_q == ST_CMD) && cs_act && sclk_rise && (cnt_q == LAST_CMD);
    assign cmd_hit  = (cmd_next[FIELD_BITS-1:0] == FIELD_BITS'(READ_ADDR)) &&
                      (cmd_next[CMD_BITS-1:FIELD_BITS] == FIELD_BITS'(READ_DATA));
    assign load     = cmd_last && cmd_hit;
    assign shift_en = (state_q == ST_READ) && cs_act && sclk_fall && (cnt_q < LAST_BIT);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cs_act) state_d = ST_CMD;
            ST_CMD: begin
                if (!cs_act)       state_d = ST_IDLE;
                else if (cmd_last) state_d = cmd_hit ? ST_READ : ST_HOLD;
            end
            ST_READ: begin
                if (!cs_act)                                  state_d = ST_IDLE;
                else if (sclk_fall && (cnt_q == LAST_BIT))    state_d = ST_HOLD;
            end
            ST_HOLD: if (!cs_act) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counter and command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmd_q <= '0;
        end else if (!cs_act || state_q == ST_IDLE) begin
            cnt_q <= '0;
            cmd_q <= '0;
        end else if (state_q == ST_CMD && sclk_rise) begin
            cmd_q <= cmd_next;
            cnt_q <= cmd_last ? '0 : cnt_q + 1'b1;
        end else if (shift_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else if (!cs_act || state_q != ST_READ) begin
            oe_q <= 1'b0;
        end else if (sclk_fall) begin
            oe_q <= (cnt_q < LAST_BIT);
        end
    end

    assign oe = oe_q;

    // R8: inactive select releases the line on the next cycle
    a_r8_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !oe_q);

    // R5: drive only in the readout state
    a_r5_oe_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> (state_q == ST_READ));

    // R5: enable only inside the sixteen bit window
    a_r5_oe_window: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> ((cnt_q >= CNT_W'(1)) && (cnt_q <= LAST_BIT)));

    // R2: command counter stays inside the command
    a_r2_cmd_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD) |-> (cnt_q <= LAST_CMD));

    // R6 and R9: the hold state never drives
    a_r9_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !oe_q);

    // R7: aborts always return to idle
    a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (state_q == ST_IDLE));

endmodule

// File: rtl/tws_readout.sv
module tws_readout #(
    parameter int FIELD_BITS  = 4,
    parameter int WORD_BITS   = 16,
    parameter int SYNC_STAGES = 2,
    parameter int READ_ADDR   = 9,
    parameter int READ_DATA   = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sclk,
    input  logic                 sdio_in,
    output logic                 sdio_out,
    output logic                 sdio_oe,
    input  logic [WORD_BITS-1:0] hold_word
);

    localparam int PIN_W = 3;

    logic [PIN_W-1:0] pins_sync;
    logic             cs_n_s, sclk_s, din_s;
    logic             sclk_prev_q;
    logic             sclk_rise, sclk_fall;
    logic             load, shift_en;

    tws_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sdio_in, sclk, cs_n}),
        .sync_out (pins_sync)
    );

    assign cs_n_s = pins_sync[0];
    assign sclk_s = pins_sync[1];
    assign din_s  = pins_sync[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_prev_q;
    assign sclk_fall = ~sclk_s & sclk_prev_q;

    tws_ctrl #(
        .FIELD_BITS (FIELD_BITS),
        .WORD_BITS  (WORD_BITS),
        .READ_ADDR  (READ_ADDR),
        .READ_DATA  (READ_DATA)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (~cs_n_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din       (din_s),
        .load      (load),
        .shift_en  (shift_en),
        .oe        (sdio_oe)
    );

    tws_shift #(
        .WORD_BITS (WORD_BITS)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift_en (shift_en),
        .par_in   (hold_word),
        .sdo      (sdio_out)
    );

endmodule

// File: tb/tws_readout_bench.sv
`timescale 1ns/1ps
module tws_readout_bench;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdio_in = 1'b0;
    logic        sdio_out;
    logic        sdio_oe;
    logic [15:0] hold_word = 16'h0000;

    int checks = 0;
    int failures = 0;

    logic [1:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    tws_readout u_tws_readout (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdio_in   (sdio_in),
        .sdio_out  (sdio_out),
        .sdio_oe   (sdio_oe),
        .hold_word (hold_word)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per master sampling edge
    initial begin
        forever begin
            @(posedge sclk);
            if (exp_q.size() == 0) begin
                check("R2 unexpected sclk", 16'd1, 16'd0);
            end else begin
                logic [1:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " oe"}, {15'd0, sdio_oe}, {15'd0, e[1]});
                if (e[1]) check({t, " bit"}, {15'd0, sdio_out}, {15'd0, e[0]});
            end
        end
    end

    // driver: queues expectations then clocks the frame
    task automatic run_frame(input logic [7:0] wire_cmd, input int nclk,
                             input logic [15:0] word_a, input logic [15:0] word_b,
                             input string tag);
        bit is_read;
        is_read = (wire_cmd == 8'b10011000);
        for (int i = 0; i < nclk; i++) begin
            if (is_read && i >= 8 && i < 24) begin
                exp_q.push_back({1'b1, word_a[23-i]});
                tag_q.push_back((word_a != word_b) ? "R4" : "R3");
            end else begin
                exp_q.push_back(2'b00);
                tag_q.push_back((i < 8) ? "R2" : (is_read ? "R9" : "R6"));
            end
        end
        hold_word = word_a;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            sdio_in = (i < 8) ? wire_cmd[7-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
            if (i == 7) hold_word = word_b;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check({tag, " R7 oe after release"}, {15'd0, sdio_oe}, 16'd0);
        check({tag, " R5 queue drained"}, 16'(exp_q.size()), 16'd0);
        repeat (HALF) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check("R1 oe", {15'd0, sdio_oe}, 16'd0);
        check("R1 sdo", {15'd0, sdio_out}, 16'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 oe after release", {15'd0, sdio_oe}, 16'd0);

        run_frame(8'b10011000, 24, 16'hA5C3, 16'hA5C3, "R3 basic");
        run_frame(8'b10011000, 24, 16'h8000, 16'h7FFF, "R4 late change");
        run_frame(8'b10011000, 24, 16'h1234, 16'hEDCB, "R4 late change b");
        run_frame(8'b10011000, 28, 16'h0001, 16'h0001, "R9 extra clocks");
        run_frame(8'b10011001, 24, 16'hFFFF, 16'hFFFF, "R6 data bit3");
        run_frame(8'b00011000, 24, 16'hFFFF, 16'hFFFF, "R6 address bit0");
        run_frame(8'b10010000, 24, 16'hFFFF, 16'hFFFF, "R6 data bit0");
        run_frame(8'b10011000, 4,  16'hFFFF, 16'hFFFF, "R7 abort command");
        run_frame(8'b10011000, 24, 16'hFFFF, 16'hFFFF, "R7 after command abort");
        run_frame(8'b10011000, 13, 16'h0F0F, 16'h0F0F, "R7 abort readout");
        run_frame(8'b10011000, 24, 16'hF0F0, 16'hF0F0, "R7 after readout abort");
        run_frame(8'b10011000, 24, 16'h0000, 16'hFFFF, "R4 zero word");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule